// File: doc/BRIEF.md
# Pixel Clock Synthesiser Parameter Search

This block turns a requested pixel period, given in picoseconds, into the three settings of a frequency synthesiser: a multiplier `p0`, a divider `p1` and a post-shift `p2`. It does this by sequential search. It first clamps the period into a legal window and picks the post-shift from a threshold. It then walks every multiplier from 1 to 31. For each one it divides the scaled base constant by the shifted period, using a restoring shift-subtract divider that retires one quotient bit per cycle. No combinational divide is needed.

A second mode works the other way. It takes a parameter triple and returns the period that the triple produces, using the same divider. Requests enter through a valid/ready handshake. Each accepted request produces exactly one single-cycle result pulse carrying the parameters, the period and an error flag. A full search takes about 31 × 34 cycles. A reverse computation takes about 36 cycles.

Top module: `pclk_param_search`

## Requirements
- R1: In search mode (`req_mode`=0), a period below 5000 is treated as 5000. The result then equals the result for 5000, and `res_period` reports 5000.
- R2: In search mode, a period greater than 2048128 (256016×8) is rejected. The result has `res_err`=1 and `res_p0`, `res_p1`, `res_p2` and `res_period` all zero.
- R3: In a successful search, `res_p2` is 3 when the clamped period ×16 is below 256016, and 2 otherwise.
- R4: The search sets l = period << p2 and starts the best remainder at l. For k = 1..31 in rising order, it forms n = (256016·k)/l and rem = (256016·k) mod l. It keeps k and n only when n ≠ 0, n < 128 and rem is strictly below the best so far. The kept k and n appear on `res_p0` (5 bits) and `res_p1` (7 bits), and `res_period` carries the clamped period.
- R5: When no multiplier passes the R4 test (for example for periods 1984125..2048128), the result has `res_err`=1 with all other result fields zero.
- R6: In reverse mode (`req_mode`=1) with `req_p1` ≠ 0, `res_period` = ((256016·`req_p0`)/`req_p1`) >> `req_p2`, using integer division, with `res_err`=0 and the parameter outputs zero.
- R7: In reverse mode with `req_p1`=0, the result has `res_err`=1 and `res_period`=0.
- R8: `req_ready` is high only while idle. It drops after a request is accepted and stays low through the result pulse.
- R9: Each accepted request yields exactly one `res_valid` pulse, one cycle long, and the result fields are valid during that pulse.
- R10: After reset, `req_ready` is 1 and `res_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted on this edge |
| req_mode | input | 1 | 0 = parameter search, 1 = period rebuild |
| req_period | input | 32 | Requested period in ps (search mode) |
| req_p0 | input | 5 | Multiplier (reverse mode) |
| req_p1 | input | 7 | Divider (reverse mode) |
| req_p2 | input | 2 | Post-shift (reverse mode) |
| res_valid | output | 1 | One-cycle result strobe |
| res_err | output | 1 | Request rejected or no solution |
| res_p0 | output | 5 | Chosen multiplier |
| res_p1 | output | 7 | Chosen divider |
| res_p2 | output | 2 | Chosen post-shift |
| res_period | output | 32 | Clamped period (search) or rebuilt period (reverse) |

## Verification
The bench builds the block with its default parameters: a 32-bit divider, base 256016, a minimum period of 5000, 31 multipliers and a divider limit of 128. It sweeps the whole legal period range in coarse steps and adds the edges: the clamp at 5000, the post-shift threshold at 16000/16001, the no-solution window starting at 1984125, and the rejection limit. A full grid of multiplier, divider and shift corner values covers the reverse mode, including divide-by-zero. Every expected triple comes from an arithmetic model of the search, run in the bench itself.

// File: rtl/pclk_pkg.sv
// Package: shared types for the pixel clock parameter search.
// Assumes: nothing beyond IEEE 1800-2017.
package pclk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SDIV,
        ST_SFIN,
        ST_RDIV,
        ST_RESP
    } pclk_state_t;

    typedef enum logic {
        MODE_SEARCH  = 1'b0,
        MODE_REVERSE = 1'b1
    } pclk_mode_t;

endpackage

// File: rtl/pclk_divu.sv
// Module: pclk_divu
// Restoring shift-subtract unsigned divider, one quotient bit per cycle.
// A start pulse loads the operands; DW cycles later a one-cycle done pulse
// marks quot/rem valid. Assumes divisor != 0 and no start while busy.
module pclk_divu #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [DW-1:0] dividend,
    input  logic [DW-1:0] divisor,
    output logic          done,
    output logic [DW-1:0] quot,
    output logic [DW-1:0] rem
);
    localparam int CW = $clog2(DW + 1);

    logic [DW-1:0] q_r, r_r, dvd_l, dvs_l;
    logic [CW-1:0] cnt;
    logic          busy;
    logic [DW:0]   r_sh;
    logic          ge;

    // Partial remainder shifted left with the next dividend bit.
    always_comb begin
        r_sh = {r_r, q_r[DW-1]};
        ge   = (r_sh >= {1'b0, dvs_l});
    end

    // Load operands on start, then one restoring step per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r   <= '0;
            r_r   <= '0;
            dvd_l <= '0;
            dvs_l <= '0;
            cnt   <= '0;
            busy  <= 1'b0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                q_r   <= dividend;
                r_r   <= '0;
                dvd_l <= dividend;
                dvs_l <= divisor;
                cnt   <= CW'(DW);
                busy  <= 1'b1;
            end else if (busy) begin
                q_r <= {q_r[DW-2:0], ge};
                r_r <= ge ? DW'(r_sh - {1'b0, dvs_l}) : r_sh[DW-1:0];
                cnt <= cnt - 1'b1;
                if (cnt == CW'(1)) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end
            end
        end
    end

    assign quot = q_r;
    assign rem  = r_r;

    // R4
    div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ((64'(quot) * 64'(dvs_l) + 64'(rem)) == 64'(dvd_l)));
    // R4
    div_rem_small_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rem < dvs_l));
    // R8
    div_no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !busy);

endmodule

// File: rtl/pclk_best_pick.sv
// Module: pclk_best_pick
// Tracks the best candidate of the search. A candidate is kept only if its
// quotient is non-zero, below NLIM, and its remainder is strictly below the
// best so far. init reloads the best remainder and clears the choice.
module pclk_best_pick #(
    parameter int DW   = 32,
    parameter int KW   = 5,
    parameter int NLIM = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     init,
    input  logic [DW-1:0]            init_rem,
    input  logic                     cand_valid,
    input  logic [KW-1:0]            cand_k,
    input  logic [DW-1:0]            cand_n,
    input  logic [DW-1:0]            cand_rem,
    output logic                     found,
    output logic [KW-1:0]            best_k,
    output logic [$clog2(NLIM)-1:0]  best_n
);
    localparam int NW = $clog2(NLIM);

    logic [DW-1:0] best_rem;
    logic          accept;

    // Acceptance test for the candidate on the input.
    always_comb begin
        accept = cand_valid && (cand_n != '0) && (cand_n < DW'(NLIM))
                 && (cand_rem < best_rem);
    end

    // Reload on init, otherwise keep the first strictly better candidate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            best_rem <= '0;
            found    <= 1'b0;
            best_k   <= '0;
            best_n   <= '0;
        end else if (init) begin
            best_rem <= init_rem;
            found    <= 1'b0;
            best_k   <= '0;
            best_n   <= '0;
        end else if (accept) begin
            best_rem <= cand_rem;
            found    <= 1'b1;
            best_k   <= cand_k;
            best_n   <= NW'(cand_n);
        end
    end

    // R4
    best_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        found |-> (best_n != '0 && best_k != '0));
    // R4
    best_rem_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !init |=> (best_rem <= $past(best_rem)));

endmodule

// File: rtl/pclk_param_search.sv
// Module: pclk_param_search
// Searches synthesiser parameters (multiplier, divider, post-shift) for a
// requested pixel period, or rebuilds the period from given parameters.
// Assumes: a request is held with req_valid until req_ready is seen high.
module pclk_param_search #(
    parameter int DW   = 32,
    parameter int BASE = 256016,
    parameter int PMIN = 5000,
    parameter int KMAX = 31,
    parameter int NLIM = 128
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     req_valid,
    output logic                     req_ready,
    input  logic                     req_mode,
    input  logic [DW-1:0]            req_period,
    input  logic [$clog2(KMAX+1)-1:0] req_p0,
    input  logic [$clog2(NLIM)-1:0]  req_p1,
    input  logic [1:0]               req_p2,
    output logic                     res_valid,
    output logic                     res_err,
    output logic [$clog2(KMAX+1)-1:0] res_p0,
    output logic [$clog2(NLIM)-1:0]  res_p1,
    output logic [1:0]               res_p2,
    output logic [DW-1:0]            res_period
);
    import pclk_pkg::*;

    localparam int            KW     = $clog2(KMAX + 1);
    localparam int            NW     = $clog2(NLIM);
    localparam logic [DW-1:0] BASE_W = DW'(BASE);
    localparam logic [DW-1:0] PMIN_W = DW'(PMIN);
    localparam logic [DW-1:0] PMAX_W = DW'(BASE) << 3;

    pclk_state_t   state;
    logic [KW-1:0] k_r;
    logic [1:0]    p2_r, rp2_r;
    logic [DW-1:0] l_r, per_r;
    logic          div_start, div_done, trk_init;
    logic [DW-1:0] div_dvd, div_dvs, div_quot, div_rem;
    logic          found;
    logic [KW-1:0] best_k;
    logic [NW-1:0] best_n;

    logic          too_big;
    logic [DW-1:0] per_c, l_c;
    logic [1:0]    sh_c;

    // Clamp, range check and post-shift choice for the incoming period.
    always_comb begin
        too_big = req_period > PMAX_W;
        per_c   = (req_period < PMIN_W) ? PMIN_W : req_period;
        sh_c    = ((per_c << 4) < BASE_W) ? 2'd3 : 2'd2;
        l_c     = per_c << sh_c;
    end

    // Request sequencer: accept, iterate multipliers, publish one result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= ST_IDLE;
            k_r        <= '0;
            p2_r       <= '0;
            rp2_r      <= '0;
            l_r        <= '0;
            per_r      <= '0;
            div_start  <= 1'b0;
            div_dvd    <= '0;
            div_dvs    <= '0;
            trk_init   <= 1'b0;
            res_valid  <= 1'b0;
            res_err    <= 1'b0;
            res_p0     <= '0;
            res_p1     <= '0;
            res_p2     <= '0;
            res_period <= '0;
        end else begin
            div_start <= 1'b0;
            trk_init  <= 1'b0;
            res_valid <= 1'b0;
            case (state)
                ST_IDLE: if (req_valid) begin
                    res_p0     <= '0;
                    res_p1     <= '0;
                    res_p2     <= '0;
                    res_period <= '0;
                    res_err    <= 1'b0;
                    if (pclk_mode_t'(req_mode) == MODE_SEARCH) begin
                        if (too_big) begin
                            res_err   <= 1'b1;
                            res_valid <= 1'b1;
                            state     <= ST_RESP;
                        end else begin
                            per_r     <= per_c;
                            p2_r      <= sh_c;
                            l_r       <= l_c;
                            trk_init  <= 1'b1;
                            k_r       <= KW'(1);
                            div_dvd   <= BASE_W;
                            div_dvs   <= l_c;
                            div_start <= 1'b1;
                            state     <= ST_SDIV;
                        end
                    end else begin
                        if (req_p1 == '0) begin
                            res_err   <= 1'b1;
                            res_valid <= 1'b1;
                            state     <= ST_RESP;
                        end else begin
                            rp2_r     <= req_p2;
                            div_dvd   <= BASE_W * DW'(req_p0);
                            div_dvs   <= DW'(req_p1);
                            div_start <= 1'b1;
                            state     <= ST_RDIV;
                        end
                    end
                end
                ST_SDIV: if (div_done) begin
                    if (k_r == KW'(KMAX)) begin
                        state <= ST_SFIN;
                    end else begin
                        k_r       <= k_r + 1'b1;
                        div_dvd   <= BASE_W * DW'(k_r + 1'b1);
                        div_start <= 1'b1;
                    end
                end
                ST_SFIN: begin
                    res_err    <= !found;
                    res_p0     <= found ? best_k : '0;
                    res_p1     <= found ? best_n : '0;
                    res_p2     <= found ? p2_r : '0;
                    res_period <= found ? per_r : '0;
                    res_valid  <= 1'b1;
                    state      <= ST_RESP;
                end
                ST_RDIV: if (div_done) begin
                    res_period <= div_quot >> rp2_r;
                    res_valid  <= 1'b1;
                    state      <= ST_RESP;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);

    pclk_divu #(.DW(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (div_start),
        .dividend (div_dvd),
        .divisor  (div_dvs),
        .done     (div_done),
        .quot     (div_quot),
        .rem      (div_rem)
    );

    pclk_best_pick #(.DW(DW), .KW(KW), .NLIM(NLIM)) u_pick (
        .clk        (clk),
        .rst_n      (rst_n),
        .init       (trk_init),
        .init_rem   (l_r),
        .cand_valid (div_done && state == ST_SDIV),
        .cand_k     (k_r),
        .cand_n     (div_quot),
        .cand_rem   (div_rem),
        .found      (found),
        .best_k     (best_k),
        .best_n     (best_n)
    );

    // R9
    resp_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);
    // R8
    busy_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !req_ready);
    // R3
    shift_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err && res_p0 != '0) |-> (res_p2 >= 2'd2));
    // R1
    clamp_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !res_err && res_p0 != '0) |-> (res_period >= PMIN_W));

endmodule

// File: tb/pclk_param_search_test.sv
`timescale 1ns/1ps
module pclk_param_search_test;
    localparam longint BASE = 256016;
    localparam longint PMIN = 5000;
    localparam longint PMAX = BASE * 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_mode = 1'b0;
    logic [31:0] req_period = '0;
    logic [4:0]  req_p0 = '0;
    logic [6:0]  req_p1 = '0;
    logic [1:0]  req_p2 = '0;
    logic        res_valid, res_err;
    logic [4:0]  res_p0;
    logic [6:0]  res_p1;
    logic [1:0]  res_p2;
    logic [31:0] res_period;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    logic        g_err;
    logic [4:0]  g_p0;
    logic [6:0]  g_p1;
    logic [1:0]  g_p2;
    logic [31:0] g_per;

    always #2.5 clk = ~clk;

    pclk_param_search uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_mode(req_mode), .req_period(req_period), .req_p0(req_p0),
        .req_p1(req_p1), .req_p2(req_p2), .res_valid(res_valid),
        .res_err(res_err), .res_p0(res_p0), .res_p1(res_p1),
        .res_p2(res_p2), .res_period(res_period)
    );

    // Watchdog: a hung run counts as a failure and still summarises.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 190000) begin
            bad = bad + 1;
            total = total + 1;
            $display("FAIL R9 watchdog expired: actual=%0d cycles expected<190000", cycles);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic check(input string req, input bit ok, input string msg);
        total = total + 1;
        if (!ok) begin
            bad = bad + 1;
            $display("FAIL %s %s", req, msg);
        end
    endtask

    // Arithmetic model of the search.
    task automatic model(input longint raw, output logic err, output logic [4:0] p0,
                         output logic [6:0] p1, output logic [1:0] p2,
                         output logic [31:0] per);
        longint pc, l, best, m, n, r;
        longint sh;
        longint bk, bn;
        err = 1'b0; p0 = '0; p1 = '0; p2 = '0; per = '0;
        if (raw > PMAX) begin
            err = 1'b1;
            return;
        end
        pc = (raw < PMIN) ? PMIN : raw;
        sh = ((pc * 16) < BASE) ? 3 : 2;
        l = pc << sh;
        best = l; bk = 0; bn = 0;
        for (int k = 1; k <= 31; k++) begin
            m = BASE * k;
            n = m / l;
            r = m % l;
            if (n != 0 && n < 128 && r < best) begin
                bk = k; bn = n; best = r;
            end
        end
        if (bk == 0) begin
            err = 1'b1;
            return;
        end
        p0 = bk[4:0]; p1 = bn[6:0]; p2 = sh[1:0]; per = pc[31:0];
    endtask

    // Issue one request, check handshake and pulse, capture the result.
    task automatic issue(input logic mode, input logic [31:0] per,
                         input logic [4:0] a, input logic [6:0] b, input logic [1:0] c);
        int cyc;
        bit rdy_bad;
        @(negedge clk);
        check("R8", req_ready === 1'b1, $sformatf("idle ready: actual=%b expected=1", req_ready));
        req_valid = 1'b1; req_mode = mode; req_period = per;
        req_p0 = a; req_p1 = b; req_p2 = c;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 0; rdy_bad = 0;
        while (!res_valid && cyc < 4000) begin
            if (req_ready) rdy_bad = 1;
            @(negedge clk);
            cyc++;
        end
        check("R8", !rdy_bad && !req_ready,
              $sformatf("ready while busy: actual=%b expected=0", rdy_bad | req_ready));
        check("R9", res_valid === 1'b1, $sformatf("result pulse: actual=%b expected=1", res_valid));
        g_err = res_err; g_p0 = res_p0; g_p1 = res_p1; g_p2 = res_p2; g_per = res_period;
        @(negedge clk);
        check("R9", res_valid === 1'b0, $sformatf("pulse width: actual=%b expected=0", res_valid));
    endtask

    task automatic search_case(input longint raw);
        logic e; logic [4:0] a; logic [6:0] b; logic [1:0] c; logic [31:0] p;
        string tag;
        model(raw, e, a, b, c, p);
        if (raw > PMAX) tag = "R2";
        else if (e) tag = "R5";
        else if (raw < PMIN) tag = "R1";
        else tag = "R4";
        issue(1'b0, raw[31:0], '0, '0, '0);
        check(tag, {g_err, g_p0, g_p1, g_per} === {e, a, b, p},
              $sformatf("period %0d: actual err=%b p0=%0d p1=%0d per=%0d expected err=%b p0=%0d p1=%0d per=%0d",
                        raw, g_err, g_p0, g_p1, g_per, e, a, b, p));
        check(e ? tag : "R3", g_p2 === c,
              $sformatf("period %0d shift: actual=%0d expected=%0d", raw, g_p2, c));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10", req_ready === 1'b1 && res_valid === 1'b0,
              $sformatf("reset: actual ready=%b valid=%b expected ready=1 valid=0", req_ready, res_valid));

        // Boundary periods: clamp, shift threshold, no-solution window, limit.
        search_case(0);
        search_case(4999);
        search_case(5000);
        search_case(5001);
        search_case(16000);
        search_case(16001);
        search_case(16002);
        search_case(1984124);
        search_case(1984125);
        search_case(2048128);
        search_case(2048129);
        search_case(64'hFFFF_FFFF);
        // Coarse sweep over the legal range.
        for (int i = 0; i < 42; i++) search_case(PMIN + longint'(i) * 49999 + 7);

        // Reverse mode grid.
        for (int ia = 0; ia < 4; ia++) begin
            for (int ib = 0; ib < 4; ib++) begin
                for (int ic = 0; ic < 4; ic++) begin
                    longint a, b, exp;
                    a = (ia == 0) ? 0 : (ia == 1) ? 1 : (ia == 2) ? 7 : 31;
                    b = (ib == 0) ? 0 : (ib == 1) ? 1 : (ib == 2) ? 5 : 127;
                    issue(1'b1, 32'd0, a[4:0], b[6:0], ic[1:0]);
                    if (b == 0) begin
                        check("R7", g_err === 1'b1 && g_per === 32'd0,
                              $sformatf("p1=0: actual err=%b per=%0d expected err=1 per=0", g_err, g_per));
                    end else begin
                        exp = ((BASE * a) / b) >> ic;
                        check("R6", g_err === 1'b0 && g_per === exp[31:0],
                              $sformatf("p0=%0d p1=%0d p2=%0d: actual err=%b per=%0d expected err=0 per=%0d",
                                        a, b, ic, g_err, g_per, exp));
                    end
                end
            end
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule